// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Processor Sequencer

This block is a small processor core that moves each 16-bit instruction through a series of one-cycle stages. Which stages run depends on the opcode. It holds sixteen 16-bit general registers and an 8-bit instruction pointer. It fetches words from a 256-entry instruction store that answers combinationally. It sends data-memory and I/O-port accesses over one request channel. Arithmetic is done by an external unit: the core drives that unit's two operands and a 3-bit operation code, and it captures the unit's result.

An instruction word holds four nibbles. Bits 15:12 are the opcode, bits 11:8 are the target or first register (T), bits 7:4 are the second register (A) and bits 3:0 are the third register (B). Bits 3:0 also serve as a 4-bit small immediate, and bits 7:0 serve as an 8-bit large immediate. The stage order is:

fetch → register read → arithmetic → memory read → memory write → write-back → pointer update

Every instruction uses a subset of these stages, in this order. All control flow is relative to the instruction pointer and wraps modulo 256.

The request channel uses valid/ready handshaking:
- `bus_valid` is high during the memory-read and memory-write stages.
- The core keeps address, write data, `bus_write` and `bus_io` stable until `bus_ready` is sampled high.
- Read data on `bus_rdata` is taken in the same cycle as the handshake.
- Each cycle that `bus_ready` stays low adds one cycle to the instruction.

Top module: `stepcore16`

## Requirements
- R1: A synchronous reset clears the instruction pointer and all registers and places the core in the fetch stage. During and right after reset, `imem_addr` is 0 and `bus_valid` is 0.
- R2: While `run` is low, the core stays in fetch. In that state `imem_rd` stays low, the pointer does not move and no request is issued.
- R3: For opcodes 0 through 7, the core drives `alu_a` from register A and `alu_b` from register B, and drives `alu_op` from opcode bits 2:0. It writes `alu_res` into register T. The instruction takes 5 cycles.
- R4: For opcode 8 (memory read) and opcode A (port read), register T receives `bus_rdata` from address A plus the zero-extended small immediate. The instruction takes 5 cycles when there is no wait.
- R5: For opcode 9 (memory write) and opcode B (port write), the core sends register T as write data to address A plus the small immediate. No register changes, and the instruction takes 4 cycles when there is no wait.
- R6: `bus_io` equals opcode bit 1, so opcodes A and B select ports. For memory accesses, `bus_addr` carries only the low 10 bits of the sum, and bits 15:10 are zero.
- R7: A request stays stable until it is accepted, and each cycle with `bus_ready` low adds exactly one cycle to the instruction.
- R8: Opcode C adds the large immediate to the pointer modulo 256, so a value of 0xFE jumps back by two. The instruction takes 2 cycles.
- R9: Opcode D adds the large immediate to the pointer when register T is nonzero. Otherwise it advances the pointer by one. The instruction takes 3 cycles.
- R10: Opcode E replaces the low byte of register T with the large immediate, and opcode F replaces the high byte. The other byte is kept, and the instruction takes 4 cycles.
- R11: Opcodes 9, B, D, E and F read registers T and A. All other opcodes read registers A and B.
- R12: `imem_rd` is high for exactly one cycle per instruction with `imem_addr` equal to the pointer. Every instruction other than a jump or branch advances the pointer by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Allows execution to leave the fetch stage |
| imem_rd | output | 1 | High during an active fetch cycle |
| imem_addr | output | 8 | Instruction pointer |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| alu_a | output | 16 | First operand to the arithmetic unit |
| alu_b | output | 16 | Second operand to the arithmetic unit |
| alu_op | output | 3 | Operation select (opcode bits 2:0) |
| alu_res | input | 16 | Arithmetic result |
| bus_valid | output | 1 | Request valid |
| bus_ready | input | 1 | Request accepted |
| bus_write | output | 1 | 1 for a write, 0 for a read |
| bus_io | output | 1 | 1 for a port access, 0 for a memory access |
| bus_addr | output | 16 | Request address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken at the handshake |

## Verification
A single program runs every opcode class.

The instruction-pointer checks:
- Byte loads build a value that later shows up in memory writes, which tells a kept byte apart from a cleared one.
- A branch on the zero register falls through, while a branch on a nonzero register is taken.
- A jump with offset 0xFE exercises the wrap modulo 256. The skipped words are writes, so a wrong pointer shows up as a write to an unexpected address.

The request-channel checks:
- Port accesses receive one cycle of back-pressure while memory accesses do not, and the cycle gap between fetches separates the two cases.
- A base of 0x07FF plus 2 lands at word 1, which checks the 10-bit truncation.
- Subtraction results read back with the expected values, showing that operands reach the arithmetic unit in the right order.

// File: rtl/stepcore_pkg.sv
package stepcore_pkg;
  typedef enum logic [2:0] {
    ST_FETCH, ST_RDREG, ST_EXEC, ST_MLOAD, ST_MSTORE, ST_WBACK, ST_ADJUST
  } stage_e;

  localparam logic [3:0] OP_LOAD  = 4'h8;
  localparam logic [3:0] OP_STORE = 4'h9;
  localparam logic [3:0] OP_PIN   = 4'hA;
  localparam logic [3:0] OP_POUT  = 4'hB;
  localparam logic [3:0] OP_JMP   = 4'hC;
  localparam logic [3:0] OP_BR    = 4'hD;
  localparam logic [3:0] OP_LLO   = 4'hE;
  localparam logic [3:0] OP_LHI   = 4'hF;

  // Opcodes whose first operand is the target register (T, A pair).
  function automatic logic reads_target(input logic [3:0] op);
    return (op == OP_STORE) || (op == OP_POUT) || (op == OP_BR) ||
           (op == OP_LLO) || (op == OP_LHI);
  endfunction
endpackage

// File: rtl/stepcore_regfile.sv
module stepcore_regfile #(
  parameter int W = 16,
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
endmodule

// File: rtl/stepcore_agen.sv
module stepcore_agen #(
  parameter int W       = 16,
  parameter int SV_W    = 4,
  parameter int DADDR_W = 10
) (
  input  logic [W-1:0]    base,
  input  logic [SV_W-1:0] small_imm,
  input  logic            is_io,
  output logic [W-1:0]    addr
);
  logic [W-1:0] sum;
  assign sum  = base + W'(small_imm);
  assign addr = is_io ? sum : {{(W-DADDR_W){1'b0}}, sum[DADDR_W-1:0]};
endmodule

// File: rtl/stepcore_seq.sv
module stepcore_seq
  import stepcore_pkg::*;
#(
  parameter int W    = 16,
  parameter int IP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [W-1:0]    fetch_word,
  input  logic            xfer_done,
  input  logic            opa_nz,
  output stage_e          stage,
  output logic [W-1:0]    ir,
  output logic [IP_W-1:0] ip
);
  logic [3:0] op;
  logic       take;
  assign op   = ir[15:12];
  assign take = (op == OP_JMP) || ((op == OP_BR) && opa_nz);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= ST_FETCH;
      ir    <= '0;
      ip    <= '0;
    end else begin
      case (stage)
        ST_FETCH: if (run) begin
          ir    <= fetch_word;
          stage <= (fetch_word[15:12] == OP_JMP) ? ST_ADJUST : ST_RDREG;
        end
        ST_RDREG: begin
          if (!op[3]) stage <= ST_EXEC;
          else if (op == OP_LOAD || op == OP_PIN) stage <= ST_MLOAD;
          else if (op == OP_STORE || op == OP_POUT) stage <= ST_MSTORE;
          else if (op == OP_BR) stage <= ST_ADJUST;
          else stage <= ST_WBACK;
        end
        ST_EXEC:   stage <= ST_WBACK;
        ST_MLOAD:  if (xfer_done) stage <= ST_WBACK;
        ST_MSTORE: if (xfer_done) stage <= ST_ADJUST;
        ST_WBACK:  stage <= ST_ADJUST;
        ST_ADJUST: begin
          ip    <= take ? ip + IP_W'(ir[7:0]) : ip + IP_W'(1);
          stage <= ST_FETCH;
        end
        default:   stage <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/stepcore16.sv
module stepcore16
  import stepcore_pkg::*;
#(
  parameter int W       = 16,
  parameter int NREG    = 16,
  parameter int IP_W    = 8,
  parameter int DADDR_W = 10,
  localparam int RA_W   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  output logic            imem_rd,
  output logic [IP_W-1:0] imem_addr,
  input  logic [W-1:0]    imem_data,
  output logic [W-1:0]    alu_a,
  output logic [W-1:0]    alu_b,
  output logic [2:0]      alu_op,
  input  logic [W-1:0]    alu_res,
  output logic            bus_valid,
  input  logic            bus_ready,
  output logic            bus_write,
  output logic            bus_io,
  output logic [W-1:0]    bus_addr,
  output logic [W-1:0]    bus_wdata,
  input  logic [W-1:0]    bus_rdata
);
  stage_e          stage;
  logic [W-1:0]    ir, opa, opb, res, rd_a, rd_b, wd;
  logic [IP_W-1:0] ip;
  logic [3:0]      op;
  logic            pair_t, xfer_done;
  logic [RA_W-1:0] ra_a, ra_b;

  assign op        = ir[15:12];
  assign pair_t    = reads_target(op);
  assign ra_a      = pair_t ? RA_W'(ir[11:8]) : RA_W'(ir[7:4]);
  assign ra_b      = pair_t ? RA_W'(ir[7:4])  : RA_W'(ir[3:0]);
  assign xfer_done = bus_valid && bus_ready;

  stepcore_seq #(.W(W), .IP_W(IP_W)) u_seq (
    .clk(clk), .rst(rst), .run(run), .fetch_word(imem_data),
    .xfer_done(xfer_done), .opa_nz(|opa), .stage(stage), .ir(ir), .ip(ip)
  );

  stepcore_regfile #(.W(W), .N(NREG)) u_rf (
    .clk(clk), .rst(rst), .ra_a(ra_a), .ra_b(ra_b), .rd_a(rd_a), .rd_b(rd_b),
    .we(stage == ST_WBACK), .wa(RA_W'(ir[11:8])), .wd(wd)
  );

  stepcore_agen #(.W(W), .SV_W(4), .DADDR_W(DADDR_W)) u_agen (
    .base(pair_t ? opb : opa), .small_imm(ir[3:0]), .is_io(op[1]),
    .addr(bus_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opa <= '0;
      opb <= '0;
      res <= '0;
    end else begin
      if (stage == ST_RDREG) begin
        opa <= rd_a;
        opb <= rd_b;
      end
      if (stage == ST_EXEC) res <= alu_res;
      if (stage == ST_MLOAD && xfer_done) res <= bus_rdata;
    end
  end

  always_comb begin
    if (op == OP_LLO)      wd = {opa[W-1:8], ir[7:0]};
    else if (op == OP_LHI) wd = {ir[7:0], opa[7:0]};
    else                   wd = res;
  end

  assign imem_rd   = (stage == ST_FETCH) && run;
  assign imem_addr = ip;
  assign alu_a     = opa;
  assign alu_b     = opb;
  assign alu_op    = ir[14:12];
  assign bus_valid = (stage == ST_MLOAD) || (stage == ST_MSTORE);
  assign bus_write = (stage == ST_MSTORE);
  assign bus_io    = op[1];
  assign bus_wdata = opa;
endmodule

// File: rtl/stepcore16_chk.sv
module stepcore16_chk #(
  parameter int W    = 16,
  parameter int IP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            imem_rd,
  input logic [IP_W-1:0] imem_addr,
  input logic            bus_valid,
  input logic            bus_ready,
  input logic            bus_write,
  input logic            bus_io,
  input logic [W-1:0]    bus_addr,
  input logic [W-1:0]    bus_wdata
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (imem_addr == '0 && !bus_valid));

  p_hold_request_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
      $stable(bus_wdata) && $stable(bus_write) && $stable(bus_io)));

  p_single_fetch_r12: assert property (@(posedge clk) disable iff (rst)
    imem_rd |=> (!imem_rd && $stable(imem_addr)));

  p_mem_window_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_io) |-> (bus_addr[W-1:10] == '0));
endmodule

bind stepcore16 stepcore16_chk #(.W(W), .IP_W(IP_W)) u_chk (.*);

// File: tb/stepcore16_test.sv
`timescale 1ns/1ps
module stepcore16_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  always #2.5 clk = ~clk;

  logic        imem_rd, bus_valid, bus_ready, bus_write, bus_io;
  logic [7:0]  imem_addr;
  logic [15:0] imem_data, alu_a, alu_b, alu_res, bus_addr, bus_wdata, bus_rdata;
  logic [2:0]  alu_op;
  logic [15:0] imem [256];
  logic [15:0] dmem [1024];
  logic        io_wait = 1'b0;

  stepcore16 uut (.*);

  assign imem_data = imem[imem_addr];
  assign bus_ready = bus_io ? io_wait : 1'b1;
  assign bus_rdata = bus_io ? 16'h0C0D + bus_addr : dmem[bus_addr[9:0]];

  always @(posedge clk) begin
    io_wait <= bus_valid && bus_io && !io_wait;
    if (bus_valid && bus_ready && bus_write && !bus_io) dmem[bus_addr[9:0]] <= bus_wdata;
  end

  logic [15:0] nb;
  assign nb = -alu_b;
  always_comb begin
    case (alu_op)
      3'd0: alu_res = alu_a + alu_b;
      3'd1: alu_res = alu_a - alu_b;
      3'd2: alu_res = alu_a * alu_b;
      3'd3: alu_res = {15'd0, alu_a < alu_b};
      3'd4: alu_res = alu_a & alu_b;
      3'd5: alu_res = alu_a | alu_b;
      3'd6: alu_res = alu_a ^ alu_b;
      default: alu_res = alu_b[15] ? alu_a >> nb : alu_a << alu_b;
    endcase
  end

  int total = 0, failed = 0, cyc = 0, last = 0;
  typedef struct { int ip; int gap; string req; } fexp_t;
  typedef struct { logic [32:0] item; string req; } wexp_t;
  fexp_t fq[$];
  wexp_t wq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_fetch(input int ip, input int gap, input string req);
    fexp_t e;
    e.ip = ip; e.gap = gap; e.req = req;
    fq.push_back(e);
  endtask

  task automatic push_write(input bit io, input int addr, input int data, input string req);
    wexp_t e;
    e.item = {io, addr[15:0], data[15:0]}; e.req = req;
    wq.push_back(e);
  endtask

  // Monitor: compares fetches and writes against the scoreboard queues.
  always @(negedge clk) begin
    cyc++;
    if (!rst && imem_rd && fq.size() > 0) begin
      fexp_t e;
      e = fq.pop_front();
      check(imem_addr == e.ip[7:0], e.req, "fetch pointer", imem_addr, e.ip);
      if (e.gap >= 0) check(cyc - last == e.gap, e.req, "cycles per instruction", cyc - last, e.gap);
      last = cyc;
    end
    if (!rst && bus_valid && bus_ready && bus_write) begin
      if (wq.size() == 0) begin
        check(1'b0, "R5", "unexpected write", {bus_io, bus_addr, bus_wdata}, 0);
      end else begin
        wexp_t w;
        w = wq.pop_front();
        check({bus_io, bus_addr, bus_wdata} == w.item, w.req, "write {io,addr,data}",
              {bus_io, bus_addr, bus_wdata}, w.item);
      end
    end
  end

  initial begin
    int wd;
    for (int i = 0; i < 256; i++) imem[i] = 16'h910F;
    for (int i = 0; i < 1024; i++) dmem[i] = 16'h0000;
    dmem[6] = 16'hBEEF;
    imem[0]  = 16'hE134; imem[1]  = 16'hF112; imem[2]  = 16'hE205;
    imem[3]  = 16'h9123; imem[4]  = 16'h0312; imem[5]  = 16'hB307;
    imem[6]  = 16'h8421; imem[7]  = 16'h9400; imem[8]  = 16'hA502;
    imem[9]  = 16'h9501; imem[10] = 16'h1612; imem[11] = 16'h9602;
    imem[12] = 16'hD005; imem[13] = 16'hD203; imem[16] = 16'hC003;
    imem[17] = 16'h9205; imem[18] = 16'hC003; imem[19] = 16'hC0FE;
    imem[21] = 16'hE177; imem[22] = 16'h9106; imem[23] = 16'hE9FF;
    imem[24] = 16'hF907; imem[25] = 16'h9192; imem[26] = 16'hC000;

    repeat (3) @(negedge clk);
    check(imem_addr == 8'd0 && !bus_valid && !imem_rd, "R1", "reset state",
          {imem_addr, bus_valid, imem_rd}, 0);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!imem_rd && imem_addr == 8'd0 && !bus_valid, "R2", "hold while run low",
            {imem_addr, bus_valid, imem_rd}, 0);
    end

    push_fetch(0, -1, "R12");  push_fetch(1, 4, "R10");  push_fetch(2, 4, "R10");
    push_fetch(3, 4, "R10");   push_fetch(4, 4, "R5");   push_fetch(5, 5, "R3");
    push_fetch(6, 5, "R7");    push_fetch(7, 5, "R4");   push_fetch(8, 4, "R5");
    push_fetch(9, 6, "R7");    push_fetch(10, 4, "R5");  push_fetch(11, 5, "R3");
    push_fetch(12, 4, "R5");   push_fetch(13, 3, "R9");  push_fetch(16, 3, "R9");
    push_fetch(19, 2, "R8");   push_fetch(17, 2, "R8");  push_fetch(18, 4, "R12");
    push_fetch(21, 2, "R8");   push_fetch(22, 4, "R10"); push_fetch(23, 4, "R12");
    push_fetch(24, 4, "R10");  push_fetch(25, 4, "R10"); push_fetch(26, 4, "R6");
    push_fetch(26, 2, "R8");

    push_write(0, 8, 16'h1234, "R11");
    push_write(1, 7, 16'h1239, "R6");
    push_write(0, 0, 16'hBEEF, "R4");
    push_write(0, 1, 16'h0C0F, "R4");
    push_write(0, 2, 16'h122F, "R3");
    push_write(0, 5, 16'h0005, "R8");
    push_write(0, 6, 16'h1277, "R10");
    push_write(0, 1, 16'h1277, "R6");

    cyc = 0;
    run = 1'b1;
    wd = 0;
    while ((fq.size() > 0 || wq.size() > 0) && wd < 5000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 5000) check(1'b0, "R12", "watchdog expired", wd, 0);
    repeat (10) @(negedge clk);
    check(wq.size() == 0 && fq.size() == 0, "R5", "scoreboard drained",
          wq.size() + fq.size(), 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule